// File: doc/BRIEF.md
# Serial Trigger and Reset Command Decoder

This block watches a single command line that is sampled on every edge of a free-running clock. A command is a three-bit frame: a leading 1 marks the start, and the two bits after it choose one of four actions: trigger, event counter reset, bunch counter reset or global reset. When a frame completes, the block raises a one-cycle pulse on the output for that action. It holds a 24-bit event counter that counts triggers. It also passes the command line on to the front-end electronics through a fixed pipeline of four clock cycles.

Test commands come in through a set/clear pair of request vectors. A set request marks a command as pending. The block then sends that command as a normal three-bit frame when the line is next free. The frame is decoded internally and forwarded like any external frame. Any frame on the external line takes precedence over a pending test command.

Top module: `cmd_decoder`

## Requirements
- R1: A frame is three consecutive sampled bits. The first is 1, then bit A, then bit B. The code {A,B} selects the action: 00 trigger, 01 event counter reset, 10 bunch counter reset, 11 global reset. The matching output pulses high for exactly one cycle, in the cycle after the third bit is sampled. At most one pulse output is high in any cycle.
- R2: While no frame is in progress, a sampled 0 on the command line starts nothing and produces no pulse.
- R3: `fe_cmd_o` equals the merged command stream (external frames plus injected frames) delayed by exactly four clock cycles.
- R4: Frames sent back to back, one every three cycles, are each decoded. Two pulses never appear in adjacent cycles.
- R5: Each trigger pulse adds one to `evt_cnt_o`, and the new value appears in the cycle after the pulse. The counter is EVT_W bits wide (default 24) and wraps to zero after its maximum value.
- R6: An event counter reset pulse or a global reset pulse sets `evt_cnt_o` to zero in the cycle after the pulse. A bunch counter reset pulse leaves the counter unchanged.
- R7: Bit i of `test_set` makes test command i pending, and bit i of `test_clr` withdraws it. If both are high in the same cycle, clear wins. The pending state is visible on `test_pend_o` in the cycle after the request. The index follows the R1 code: 0 trigger, 1 event counter reset, 2 bunch counter reset, 3 global reset.
- R8: A pending test command with index i is sent as the bits 1, i[1], i[0]. It starts in the first cycle when no frame is in progress and the external line is 0. Its pending bit clears as the frame starts, and the frame is decoded exactly like an external frame.
- R9: When several test commands are pending, the one with the highest index is sent first. The others follow one frame after another.
- R10: When a 1 appears on the external line in the same cycle that a pending test command could start, the external frame is taken. The test command starts in the first free cycle after that frame.
- R11: During an injected frame the external line is not sampled. A 1 on it during the last two bits of an injected frame has no effect on pulses, on the counter, or on `fe_cmd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the command line |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_in | input | 1 | Serial command line from the trigger source |
| test_set | input | 4 | Set requests for pending test commands, indexed by code |
| test_clr | input | 4 | Clear requests for pending test commands |
| trig_o | output | 1 | One-cycle trigger pulse |
| ecr_o | output | 1 | One-cycle event counter reset pulse |
| bcr_o | output | 1 | One-cycle bunch counter reset pulse |
| grst_o | output | 1 | One-cycle global reset pulse |
| fe_cmd_o | output | 1 | Merged command stream delayed by four cycles |
| evt_cnt_o | output | EVT_W | Event counter |
| test_pend_o | output | 4 | Pending test commands |

## Verification
A command pulse is due one cycle after the third bit of its frame is sampled, and the counter changes one cycle after that pulse. Each forwarded bit reappears four cycles after it was sampled. An injected frame starts one cycle after the set request if the line is free, so its pulse is due four cycles after the request. The driver labels every sampled bit with the cycle in which it is sampled, and places each expected pulse in a queue at the exact cycle it is due. The monitor compares the pulse outputs, the counter and the forwarded line in every cycle, on the falling edge, against those labelled expectations.

// File: rtl/cmd_decoder_pkg.sv
package cmd_decoder_pkg;
    localparam int N_CMD  = 4;
    localparam int CODE_W = $clog2(N_CMD);

    typedef enum logic [CODE_W-1:0] {
        CMD_TRIG = 2'd0,
        CMD_ECR  = 2'd1,
        CMD_BCR  = 2'd2,
        CMD_GRST = 2'd3
    } cmd_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BITA = 2'd1,
        PH_BITB = 2'd2
    } phase_t;

    typedef struct packed {
        phase_t             ph;
        logic               from_inj;
        logic [CODE_W-1:0]  code;
        logic [N_CMD-1:0]   pulse;
    } framer_st_t;
endpackage

// File: rtl/cmd_inj_arbiter.sv
module cmd_inj_arbiter
    import cmd_decoder_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_CMD-1:0]    set_i,
    input  logic [N_CMD-1:0]    clr_i,
    input  logic                take_i,
    output logic [N_CMD-1:0]    pend_o,
    output logic                req_o,
    output logic [CODE_W-1:0]   code_o
);
    logic [N_CMD-1:0]  pend_d, pend_q;
    logic [CODE_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < N_CMD; i++) begin
            if (pend_q[i]) pick = i[CODE_W-1:0];
        end
        pend_d = pend_q;
        if (take_i) pend_d[pick] = 1'b0;
        pend_d = (pend_d | set_i) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;
    assign req_o  = |pend_q;
    assign code_o = pick;
endmodule

// File: rtl/cmd_framer.sv
module cmd_framer
    import cmd_decoder_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_i,
    input  logic                req_i,
    input  logic [CODE_W-1:0]   code_i,
    output logic                take_o,
    output logic                line_o,
    output logic [N_CMD-1:0]    pulse_o
);
    framer_st_t st_q, st_d;
    logic       bit_now;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = '0;
        take_o     = 1'b0;
        bit_now    = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (ext_i) begin
                    bit_now       = 1'b1;
                    st_d.ph       = PH_BITA;
                    st_d.from_inj = 1'b0;
                end else if (req_i) begin
                    bit_now       = 1'b1;
                    take_o        = 1'b1;
                    st_d.ph       = PH_BITA;
                    st_d.from_inj = 1'b1;
                    st_d.code     = code_i;
                end
            end
            PH_BITA: begin
                bit_now      = st_q.from_inj ? st_q.code[1] : ext_i;
                st_d.code[1] = bit_now;
                st_d.ph      = PH_BITB;
            end
            PH_BITB: begin
                bit_now = st_q.from_inj ? st_q.code[0] : ext_i;
                st_d.pulse[{st_q.code[1], bit_now}] = 1'b1;
                st_d.ph = PH_IDLE;
            end
            default: st_d.ph = PH_IDLE;
        endcase
        line_o = bit_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, from_inj: 1'b0, code: '0, pulse: '0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/cmd_fwd_delay.sv
module cmd_fwd_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    generate
        if (DEPTH == 1) begin : g_one
            logic sh_d, sh_q;
            always_comb sh_d = line_i;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= 1'b0;
                else        sh_q <= sh_d;
            end
            assign line_o = sh_q;
        end else begin : g_many
            logic [DEPTH-1:0] sh_d, sh_q;
            always_comb sh_d = {sh_q[DEPTH-2:0], line_i};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end
            assign line_o = sh_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/cmd_evt_counter.sv
module cmd_evt_counter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import cmd_decoder_pkg::*;
#(
    parameter int EVT_W     = 24,
    parameter int FWD_DELAY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_in,
    input  logic [3:0]       test_set,
    input  logic [3:0]       test_clr,
    output logic             trig_o,
    output logic             ecr_o,
    output logic             bcr_o,
    output logic             grst_o,
    output logic             fe_cmd_o,
    output logic [EVT_W-1:0] evt_cnt_o,
    output logic [3:0]       test_pend_o
);
    logic              take_w, req_w, line_w;
    logic [CODE_W-1:0] code_w;
    logic [N_CMD-1:0]  pulse_w;

    cmd_inj_arbiter u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (test_set),
        .clr_i  (test_clr),
        .take_i (take_w),
        .pend_o (test_pend_o),
        .req_o  (req_w),
        .code_o (code_w)
    );

    cmd_framer u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_i   (cmd_in),
        .req_i   (req_w),
        .code_i  (code_w),
        .take_o  (take_w),
        .line_o  (line_w),
        .pulse_o (pulse_w)
    );

    cmd_fwd_delay #(.DEPTH(FWD_DELAY)) u_fwd (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (line_w),
        .line_o (fe_cmd_o)
    );

    cmd_evt_counter #(.W(EVT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (pulse_w[CMD_TRIG]),
        .clr_i (pulse_w[CMD_ECR] | pulse_w[CMD_GRST]),
        .cnt_o (evt_cnt_o)
    );

    assign trig_o = pulse_w[CMD_TRIG];
    assign ecr_o  = pulse_w[CMD_ECR];
    assign bcr_o  = pulse_w[CMD_BCR];
    assign grst_o = pulse_w[CMD_GRST];
endmodule

// File: rtl/cmd_decoder_chk.sv
module cmd_decoder_chk #(
    parameter int EVT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             ecr,
    input logic             bcr,
    input logic             grst,
    input logic             line,
    input logic             fe,
    input logic [EVT_W-1:0] cnt
);
    logic [2:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             since_q <= '0;
        else if (since_q != 3'd4) since_q <= since_q + 3'd1;
    end

    // R1
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trig, ecr, bcr, grst}));

    // R3
    fwd_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 3'd4) |-> (fe == $past(line, 4)));

    // R4
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig || ecr || bcr || grst) |=> !(trig || ecr || bcr || grst));

    // R5
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == $past(cnt) + 1'b1));

    // R6
    cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ecr || grst) |=> (cnt == '0));

    // R6
    bcr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcr |=> $stable(cnt));
endmodule

bind cmd_decoder cmd_decoder_chk #(.EVT_W(EVT_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .trig (trig_o),
    .ecr  (ecr_o),
    .bcr  (bcr_o),
    .grst (grst_o),
    .line (line_w),
    .fe   (fe_cmd_o),
    .cnt  (evt_cnt_o)
);

// File: tb/cmd_decoder_test.sv
module cmd_decoder_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_in = 1'b0;
    logic [3:0]  test_set = '0;
    logic [3:0]  test_clr = '0;
    logic        trig_o, ecr_o, bcr_o, grst_o, fe_cmd_o;
    logic [23:0] evt_cnt_o;
    logic [3:0]  test_pend_o;
    logic        w_trig, w_ecr, w_bcr, w_grst, w_fe;
    logic [2:0]  w_cnt;
    logic [3:0]  w_pend;

    always #(CLK_P/2) clk = ~clk;

    cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .test_set(test_set), .test_clr(test_clr),
        .trig_o(trig_o), .ecr_o(ecr_o), .bcr_o(bcr_o), .grst_o(grst_o), .fe_cmd_o(fe_cmd_o),
        .evt_cnt_o(evt_cnt_o), .test_pend_o(test_pend_o)
    );

    cmd_decoder #(.EVT_W(3)) uut_w (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in), .test_set(test_set), .test_clr(test_clr),
        .trig_o(w_trig), .ecr_o(w_ecr), .bcr_o(w_bcr), .grst_o(w_grst), .fe_cmd_o(w_fe),
        .evt_cnt_o(w_cnt), .test_pend_o(w_pend)
    );

    typedef struct { int due; int kind; string tag; } item_t;
    item_t       expq[$];
    bit          exp_line [0:1023];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int unsigned model = 0;
    bit          done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: got %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic void push_exp(input int due, input int kind, input string tag);
        int i;
        item_t it;
        i = 0;
        while (i < expq.size() && expq[i].due <= due) i++;
        it.due = due; it.kind = kind; it.tag = tag;
        expq.insert(i, it);
    endfunction

    // scoreboard monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && cyc >= 1 && !done) begin : mon
            logic [3:0] pv;
            logic [3:0] ev;
            bit         efe;
            int         k;
            string      tag;
            efe = (cyc >= 4) ? exp_line[cyc-4] : 1'b0;
            check(fe_cmd_o == efe, "R3", "fe_cmd_o", fe_cmd_o, efe);
            check(evt_cnt_o == model[23:0], "R5/R6", "evt_cnt_o", evt_cnt_o, model[23:0]);
            check(w_cnt == model[2:0], "R5", "narrow counter wrap", w_cnt, model[2:0]);
            pv = {grst_o, bcr_o, ecr_o, trig_o};
            if (expq.size() > 0 && expq[0].due == cyc) begin
                k   = expq[0].kind;
                tag = expq[0].tag;
                ev  = 4'b0001 << k;
                void'(expq.pop_front());
            end else begin
                k   = -1;
                tag = "R2";
                ev  = 4'b0000;
            end
            check(pv == ev, tag, "pulses {grst,bcr,ecr,trig}", pv, ev);
            if (k == 0) model = model + 1;
            else if (k == 1 || k == 3) model = 0;
        end
    end

    task automatic drive(input bit b, input logic [3:0] s, input logic [3:0] c, input bit rec);
        @(negedge clk);
        cmd_in   = b;
        test_set = s;
        test_clr = c;
        if (rec) exp_line[cyc] = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 4'h0, 4'h0, 1'b0);
    endtask

    task automatic send(input logic [1:0] kind, input string tag);
        drive(1'b1, 4'h0, 4'h0, 1'b1);
        drive(kind[1], 4'h0, 4'h0, 1'b1);
        drive(kind[0], 4'h0, 4'h0, 1'b1);
        push_exp(cyc + 1, int'(kind), tag);
    endtask

    task automatic expect_inj(input int start, input logic [1:0] kind, input string tag);
        exp_line[start]     = 1'b1;
        exp_line[start + 1] = kind[1];
        exp_line[start + 2] = kind[0];
        push_exp(start + 3, int'(kind), tag);
    endtask

    task automatic chk_pend(input logic [3:0] e, input string tag);
        check(test_pend_o == e, tag, "test_pend_o", test_pend_o, e);
    endtask

    initial begin : watchdog
        #(CLK_P * 20000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog: got running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int n;
        repeat (3) @(negedge clk);
        // reset state
        check({trig_o, ecr_o, bcr_o, grst_o, fe_cmd_o} == 5'b0, "R1", "pulses in reset", 0, 0);
        check(evt_cnt_o == '0, "R5", "counter in reset", evt_cnt_o, 0);
        check(test_pend_o == '0, "R7", "pending in reset", test_pend_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: idle zeros ignored
        idle(6);

        // R1 R4 R5: back-to-back triggers
        send(2'b00, "R4");
        send(2'b00, "R4");
        send(2'b00, "R5");
        idle(2);
        // R6: bunch reset holds counter, event reset clears it
        send(2'b10, "R6");
        idle(1);
        send(2'b01, "R6");
        send(2'b00, "R1");
        send(2'b00, "R1");
        idle(3);
        send(2'b11, "R6");
        idle(2);

        // R7 R8: single injected trigger
        drive(1'b0, 4'b0001, 4'h0, 1'b0);
        n = cyc;
        expect_inj(n + 1, 2'b00, "R8");
        drive(1'b0, 4'h0, 4'h0, 1'b0);
        chk_pend(4'b0001, "R7");
        drive(1'b0, 4'h0, 4'h0, 1'b0);
        chk_pend(4'b0000, "R8");
        idle(4);

        // R9: global reset before trigger when both pending
        drive(1'b0, 4'b1001, 4'h0, 1'b0);
        n = cyc;
        expect_inj(n + 1, 2'b11, "R9");
        expect_inj(n + 4, 2'b00, "R9");
        idle(9);

        // R10: external frame wins the idle cycle
        drive(1'b0, 4'b0010, 4'h0, 1'b0);
        n = cyc;
        send(2'b10, "R10");
        expect_inj(n + 4, 2'b01, "R10");
        idle(6);

        // R7: clear withdraws a pending command before it can start
        drive(1'b1, 4'b0100, 4'h0, 1'b1);
        n = cyc;
        drive(1'b0, 4'h0, 4'b0100, 1'b1);
        chk_pend(4'b0100, "R7");
        drive(1'b0, 4'h0, 4'h0, 1'b1);
        chk_pend(4'b0000, "R7");
        push_exp(n + 3, 0, "R1");
        idle(5);
        chk_pend(4'b0000, "R7");

        // R11: external 1 during an injected frame body is ignored
        drive(1'b0, 4'b0001, 4'h0, 1'b0);
        n = cyc;
        expect_inj(n + 1, 2'b00, "R11");
        drive(1'b0, 4'h0, 4'h0, 1'b0);
        drive(1'b1, 4'h0, 4'h0, 1'b0);
        drive(1'b0, 4'h0, 4'h0, 1'b0);
        idle(4);

        // R5: wrap of the narrow counter instance
        for (int i = 0; i < 10; i++) send(2'b00, "R5");
        idle(8);

        check(expq.size() == 0, "R1", "outstanding expected pulses", expq.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule